// File: doc/BRIEF.md
# Two-Register Serial Control Port

This block is a slave on a two-wire serial control bus in the 100 kHz class. It gives a host access to two 8-bit control registers of an image sensor's timing core. The first register holds the exposure setting and the second holds the operating mode. A faster system clock oversamples the bus clock and data lines. The block detects START, repeated START and STOP conditions and answers only to the 7-bit device address 0110011. The write calling byte is 66h and the read calling byte is 67h.

Each transaction between a START and a STOP moves exactly one register. A write sends the calling byte 66h, then a register index, then one data byte. A read first sets the register pointer with a write-addressed index phase. It then issues a repeated START and the calling byte 67h, and the slave returns one byte. The mode register drives its decoded bits to the outputs as soon as a write completes. Exposure writes go into a staging register, and the staged value moves to the exposure output when a frame-boundary pulse arrives. The bus data line is open-drain: the block only ever asserts a pull-low enable.

Top module: `sensor_ctrl_i2c`

## Requirements
- R1: After reset, exposure_o is 00h, every mode output is 0 and sda_oe_o is 0. A value of 00h selects continuous capture, progressive scan, CDS off, on-chip clocks and full-frame exposure.
- R2: The slave drives SDA low during the ninth clock of a byte only when the calling byte carries address 0110011. With any other address it never drives SDA and ignores the bus until the next START or STOP.
- R3: A complete write of data D to register index 01h makes the mode outputs equal D[5:0] immediately after the ninth clock of the data byte. The bit positions are: standby_o=D[5], interlace_o=D[4] (1 interlaced, 0 progressive), single_frame_o=D[3] (1 single-frame, 0 continuous), cds_on_o=D[2], mon_hclk_o=D[1] (1 horizontal clock, 0 start-of-frame), ext_clk_o=D[0] (1 user-supplied clocks, 0 on-chip).
- R4: Bits 7 and 6 of the mode register always hold 0, whatever value is written.
- R5: A write to register index 00h changes only the staging register. exposure_o takes the staged value one cycle after a frame_start_i pulse and does not change otherwise.
- R6: A read consists of an index phase with 66h, a repeated START and the calling byte 67h. The slave then returns the addressed register MSB first: the staged exposure value for index 00h, or the mode register for index 01h.
- R7: Register indices other than 00h and 01h are acknowledged. A write to such an index changes no register, and a read returns 00h.
- R8: A STOP or START that arrives before the ninth clock of the data byte has ended commits nothing, and SDA is released.
- R9: When init_i is held high for INIT_CYCLES (8) consecutive clocks, the protocol state, the pointer and both registers clear. A shorter pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialise request; takes effect after being held for INIT_CYCLES clocks |
| frame_start_i | input | 1 | Frame-boundary pulse that moves the staged exposure value to exposure_o |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| exposure_o | output | 8 | Active exposure setting |
| standby_o | output | 1 | Standby select |
| interlace_o | output | 1 | 1 interlaced scan, 0 progressive scan |
| single_frame_o | output | 1 | 1 single-frame capture, 0 continuous capture |
| cds_on_o | output | 1 | Correlated double sampling enable |
| mon_hclk_o | output | 1 | Monitor pin select: 1 horizontal clock, 0 start-of-frame |
| ext_clk_o | output | 1 | 1 user-supplied vertical and horizontal clocks, 0 on-chip clocks |

## Verification
Mode writes use an all-ones pattern and a sparse pattern. The all-ones pattern shows that the reserved upper bits are masked. The sparse pattern shows that each output follows its own bit position and is not tied to a neighbour. Exposure is written without a frame pulse, read back, and then observed after the pulse, which separates the staged copy from the active copy. A foreign calling byte, an out-of-range register index and data bytes cut short by STOP or by a repeated START each show that nothing reaches the registers unless the full sequence completes. Init pulses of seven and eight clocks bracket the reset threshold.

// File: rtl/sensor_ctrl_pkg.sv
package sensor_ctrl_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned MODE_W = 6;
  localparam logic [DW-1:0] IDX_EXPO = 8'h00;
  localparam logic [DW-1:0] IDX_MODE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_DATA, ST_ACK, ST_TX, ST_WAIT
  } bus_st_e;
endpackage

// File: rtl/init_filter.sv
module init_filter #(
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  output logic clr_o
);
  localparam int unsigned CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);
  localparam logic [CW-1:0] SAT = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!init_i)     cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  // clear fires on the INIT_CYCLES-th consecutive high cycle and while held
  assign clr_o = init_i && (cnt_q >= LAST);
endmodule

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl_q, sda_q, scl_w;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_s <= '1;
          sda_s <= '1;
        end else begin
          scl_s <= scl_i;
          sda_s <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_s <= '1;
          sda_s <= '1;
        end else begin
          scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
          sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_w = scl_s[SYNC_STAGES-1];
  assign sda_o = sda_s[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_w;
      sda_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_w && !scl_q;
  assign scl_fall_o = !scl_w && scl_q;
  assign start_o    = scl_w && scl_q && sda_q && !sda_o;
  assign stop_o     = scl_w && scl_q && !sda_q && sda_o;
endmodule

// File: rtl/bus_slave_fsm.sv
module bus_slave_fsm
  import sensor_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0110011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] ptr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_stb_o,
  output logic          sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  bus_st_e          state_q, ack_of_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    shreg_q, ptr_q;
  logic             rw_q, oe_q, stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ack_of_q <= ST_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      stb_q    <= 1'b0;
    end else if (clr_i) begin
      state_q  <= ST_IDLE;
      ack_of_q <= ST_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_REG, ST_DATA: begin
            if (scl_rise_i && cnt_q != FULL) begin
              shreg_q <= {shreg_q[DW-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR && shreg_q[DW-1:1] != DEV_ADDR) begin
                state_q <= ST_WAIT;
              end else begin
                oe_q     <= 1'b1;
                ack_of_q <= state_q;
                state_q  <= ST_ACK;
                if (state_q == ST_ADDR) rw_q  <= shreg_q[0];
                if (state_q == ST_REG)  ptr_q <= shreg_q;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              if (ack_of_q == ST_ADDR) begin
                if (rw_q) begin
                  state_q <= ST_TX;
                  shreg_q <= rd_data_i;
                  oe_q    <= ~rd_data_i[DW-1];
                end else begin
                  state_q <= ST_REG;
                end
              end else if (ack_of_q == ST_REG) begin
                state_q <= ST_DATA;
              end else begin
                stb_q   <= 1'b1;
                state_q <= ST_WAIT;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                oe_q    <= 1'b0;
                state_q <= ST_WAIT;
              end else begin
                shreg_q <= {shreg_q[DW-2:0], 1'b0};
                oe_q    <= ~shreg_q[DW-2];
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_data_o = shreg_q;
  assign wr_stb_o  = stb_q;
  assign sda_oe_o  = oe_q;
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import sensor_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_stb_i,
  input  logic [DW-1:0]     idx_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              frame_start_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [DW-1:0]     expo_o,
  output logic [DW-1:0]     rd_data_o
);
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0]     stage_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      stage_q  <= '0;
      active_q <= '0;
    end else if (clr_i) begin
      mode_q   <= '0;
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      if (wr_stb_i && idx_i == IDX_MODE) mode_q  <= wr_data_i[MODE_W-1:0];
      if (wr_stb_i && idx_i == IDX_EXPO) stage_q <= wr_data_i;
      if (frame_start_i)                 active_q <= stage_q;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_EXPO: rd_data_o = stage_q;
      IDX_MODE: rd_data_o = {{(DW-MODE_W){1'b0}}, mode_q};
      default:  rd_data_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign expo_o = active_q;
endmodule

// File: rtl/sensor_ctrl_i2c.sv
module sensor_ctrl_i2c
  import sensor_ctrl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b0110011,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          frame_start_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] exposure_o,
  output logic          standby_o,
  output logic          interlace_o,
  output logic          single_frame_o,
  output logic          cds_on_o,
  output logic          mon_hclk_o,
  output logic          ext_clk_o
);
  logic              init_clr;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0]     ptr, wr_data, rd_data;
  logic              wr_stb;
  logic [MODE_W-1:0] mode_q;

  init_filter #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .clr_o(init_clr)
  );

  bus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  bus_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(init_clr), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_det),
    .stop_i(stop_det), .rd_data_i(rd_data), .ptr_o(ptr),
    .wr_data_o(wr_data), .wr_stb_o(wr_stb), .sda_oe_o(sda_oe_o)
  );

  ctrl_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(init_clr), .wr_stb_i(wr_stb),
    .idx_i(ptr), .wr_data_i(wr_data), .frame_start_i(frame_start_i),
    .mode_o(mode_q), .expo_o(exposure_o), .rd_data_o(rd_data)
  );

  assign standby_o      = mode_q[5];
  assign interlace_o    = mode_q[4];
  assign single_frame_o = mode_q[3];
  assign cds_on_o       = mode_q[2];
  assign mon_hclk_o     = mode_q[1];
  assign ext_clk_o      = mode_q[0];
endmodule

// File: rtl/sensor_ctrl_i2c_chk.sv
module sensor_ctrl_i2c_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       init_clr,
  input logic       frame_start_i,
  input logic [7:0] exposure_o,
  input logic [5:0] mode_q,
  input logic       wr_stb,
  input logic       sda_oe_o,
  input logic       scl_fall
);
  // R5: active exposure moves only on a frame pulse (or init clear)
  assert_expo_on_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exposure_o != $past(exposure_o)) |-> ($past(frame_start_i) || $past(init_clr)));

  // R3: mode changes only after a committed write strobe (or init clear)
  assert_mode_on_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> ($past(wr_stb) || $past(init_clr)));

  // R2: slave starts pulling SDA only right after SCL has fallen
  assert_drive_after_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R8: a commit is a single-cycle event
  assert_single_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !wr_stb);

  // R9: init clear releases the bus and empties both registers
  assert_init_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_clr |=> (!sda_oe_o && mode_q == 6'd0 && exposure_o == 8'd0));
endmodule

bind sensor_ctrl_i2c sensor_ctrl_i2c_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_clr(init_clr),
  .frame_start_i(frame_start_i), .exposure_o(exposure_o), .mode_q(mode_q),
  .wr_stb(wr_stb), .sda_oe_o(sda_oe_o), .scl_fall(scl_fall)
);

// File: tb/sensor_ctrl_i2c_test.sv
module sensor_ctrl_i2c_test;
  localparam int Q = 10;

  logic clk = 1'b0, rst_ni = 1'b0, init = 1'b0, frame = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] expo;
  logic stby, intl, sngl, cds, monh, extc;
  wire  sda_bus = sda_m & ~sda_oe;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  sensor_ctrl_i2c uut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init), .frame_start_i(frame),
    .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe), .exposure_o(expo),
    .standby_o(stby), .interlace_o(intl), .single_frame_o(sngl),
    .cds_on_o(cds), .mon_hclk_o(monh), .ext_clk_o(extc)
  );

  function automatic logic [5:0] mode_pins();
    return {stby, intl, sngl, cds, monh, extc};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    clk_bits(b, 8);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(Q / 2);
    acked = ~sda_bus;
    wq(Q / 2); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(Q / 2); b[i] = sda_bus; wq(Q / 2); scl = 1'b0;
    end
    wq(); scl = 1'b1; wq(); scl = 1'b0; wq();  // master NACK
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'h66, a); chk("R2 ack addr", {7'd0, a}, 8'd1);
    send_byte(idx, a);   chk("R2 ack index", {7'd0, a}, 8'd1);
    send_byte(d, a);     chk("R2 ack data", {7'd0, a}, 8'd1);
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'h66, a);
    send_byte(idx, a);
    bus_start();
    send_byte(8'h67, a); chk("R6 ack read call", {7'd0, a}, 8'd1);
    recv_byte(d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 exposure", expo, 8'h00);
    chk("R1 mode", {2'b00, mode_pins()}, 8'h00);
    chk("R1 sda released", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    reg_write(8'h01, 8'hFF);
    chk("R3 R4 all ones", {2'b00, mode_pins()}, 8'h3F);
    reg_read(8'h01, d);
    chk("R4 R6 readback reserved 0", d, 8'h3F);
    reg_write(8'h01, 8'h14);
    chk("R3 interlace+cds", {2'b00, mode_pins()}, 8'h14);
    chk("R3 interlace_o", {7'd0, intl}, 8'h01);
    chk("R3 single_frame_o", {7'd0, sngl}, 8'h00);
  endtask

  task automatic t_expo();
    logic [7:0] d;
    reg_write(8'h00, 8'h5A);
    chk("R5 staged not active", expo, 8'h00);
    reg_read(8'h00, d);
    chk("R6 read staged exposure", d, 8'h5A);
    @(negedge clk) frame = 1'b1;
    @(negedge clk) frame = 1'b0;
    chk("R5 active after frame", expo, 8'h5A);
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    send_byte(8'h68, a); chk("R2 no ack foreign", {7'd0, a}, 8'd0);
    send_byte(8'h01, a); chk("R2 ignored index", {7'd0, a}, 8'd0);
    send_byte(8'h21, a);
    bus_stop();
    chk("R2 mode unchanged", {2'b00, mode_pins()}, 8'h14);
  endtask

  task automatic t_other_idx();
    logic [7:0] d;
    reg_write(8'h07, 8'hAA);
    chk("R7 mode unchanged", {2'b00, mode_pins()}, 8'h14);
    reg_read(8'h07, d);
    chk("R7 read other idx", d, 8'h00);
    reg_read(8'h00, d);
    chk("R7 exposure stage unchanged", d, 8'h5A);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte(8'h66, a); send_byte(8'h01, a);
    clk_bits(8'h3F, 4);
    bus_stop();
    chk("R8 stop mid-byte", {2'b00, mode_pins()}, 8'h14);
    chk("R8 sda released", {7'd0, sda_oe}, 8'h00);
    bus_start();
    send_byte(8'h66, a); send_byte(8'h01, a);
    clk_bits(8'h2B, 3);
    bus_start();
    bus_stop();
    chk("R8 restart mid-byte", {2'b00, mode_pins()}, 8'h14);
  endtask

  task automatic t_init();
    @(negedge clk) init = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk) init = 1'b0;
    wq(2);
    chk("R9 short init ignored", {2'b00, mode_pins()}, 8'h14);
    chk("R9 short init expo", expo, 8'h5A);
    @(negedge clk) init = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk) init = 1'b0;
    wq(2);
    chk("R9 init clears mode", {2'b00, mode_pins()}, 8'h00);
    chk("R9 init clears expo", expo, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wq(4);
    rst_ni = 1'b1;
    wq(4);
    t_reset();
    t_mode();
    t_expo();
    t_foreign();
    t_other_idx();
    t_abort();
    t_init();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule